// File: doc/BRIEF.md
# Dual-Tone Complex Baseband Generator

This block produces one complex baseband sample per accepted clock as the sum of two independent, amplitude-scaled complex tones. Each tone keeps a wide phase accumulator that steps by its own frequency word. A phase offset word is added to the top of that accumulator, and the result addresses a sine/cosine lookup. The looked-up pair is scaled by the tone's signed amplitude. The two scaled I/Q pairs are then added into one I/Q stream that is one bit wider than a single tone, so the sum never wraps.

Upstream interpolators present the two frequency, phase and amplitude words together with a sample strobe. A later stage takes the I/Q output and the matching valid for upconversion. A synchronous phase-clear input restarts both accumulators together, so both tones start from a known phase. The lookup is a computed quarter-wave table that is folded by quadrant. Both tones and both I/Q lanes have the same fixed pipeline depth.

Top module: `dualToneGen`

## Requirements
- R1: While reset is high, and after reset until the first accepted sample has come through, `outValid` is 0 and `outI`/`outQ` are 0.
- R2: A sample accepted at a clock edge (`sampleEn`=1) appears on `outI`/`outQ` with `outValid`=1 exactly three clock edges later, one output per accepted sample, in order.
- R3: Each tone's 48-bit accumulator steps by its frequency word (mod 2^48) on every accepted sample. The 16-bit phase index of a sample is accumulator bits [47:32], taken before that step, plus the phase word, mod 2^16.
- R4: The lookup address is phase index bits [15:6] (n, 0..1023). With T(j) = round(32767*4u/(327680-u)), u = j*(512-j), j = 0..256, sin(n) is +T(m) in quadrant 0, +T(256-m) in quadrant 1, -T(m) in quadrant 2 and -T(256-m) in quadrant 3. Here the quadrant is n[9:8] and m = n[7:0]. cos(n) = sin((n+256) mod 1024).
- R5: Each tone contributes I = floor(a*cos/32768) and Q = floor(a*sin/32768), where a is its amplitude word as signed two's complement. A zero amplitude contributes nothing.
- R6: `outI`/`outQ` are the 17-bit signed sums of the two tones' contributions and never wrap, also with both amplitudes at +32767 or at -32768.
- R7: When `sampleEn` is 0, neither accumulator moves, `outValid` stays low three edges later, and `outI`/`outQ` hold their last values.
- R8: When `phaseClear` is 1 at an edge, both accumulators are taken as zero for that edge: a sample accepted there uses a phase index equal to its phase word, and each accumulator is then left holding its frequency word if the sample was accepted, or 0 if it was not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Accept one sample and step both accumulators |
| phaseClear | input | 1 | Zero both accumulators at this edge |
| freqA | input | 48 | Tone A phase step per sample |
| phaseA | input | 16 | Tone A phase offset |
| ampA | input | 16 | Tone A amplitude, signed |
| freqB | input | 48 | Tone B phase step per sample |
| phaseB | input | 16 | Tone B phase offset |
| ampB | input | 16 | Tone B amplitude, signed |
| outI | output | 17 | Summed in-phase sample, signed |
| outQ | output | 17 | Summed quadrature sample, signed |
| outValid | output | 1 | High for one cycle per produced sample |

## Verification
A corrupted accumulator shows on the very next produced sample as a wrong I/Q pair. It then keeps causing errors on every later sample of that tone until a phase clear, because the phase error never decays. A wrong table entry or quadrant fold shows only when the phase index lands in the affected address range. The bench therefore sweeps random phase words and frequency steps, including steps that wrap the accumulator. A wrong depth in the valid pipeline shows three edges after the first accepted sample as a valid pulse at the wrong edge, or as a value paired with the wrong sample.

// File: rtl/dtgPkg.sv
package dtgPkg;
  localparam int NUM_TONES   = 2;
  localparam int PIPE_STAGES = 3;

  typedef struct packed {
    logic advance;
    logic clear;
    logic loadOut;
  } dtgStrobes_t;
endpackage

// File: rtl/sinCosLut.sv
module sinCosLut #(
  parameter int AW = 10,
  parameter int SW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr,
  output logic signed [SW-1:0] sinOut,
  output logic signed [SW-1:0] cosOut
);
  localparam int  Q    = 1 << (AW - 2);
  localparam longint SMAX = (longint'(1) << (SW - 1)) - 1;

  function automatic longint quarterVal(input int j);
    longint u;
    longint d;
    u = longint'(j) * longint'(2 * Q - j);
    d = longint'(5) * Q * Q - u;
    return (SMAX * 4 * u + d / 2) / d;
  endfunction

  logic [SW-1:0] quarterTab [Q+1];
  for (genvar j = 0; j <= Q; j++) begin : g_tab
    assign quarterTab[j] = SW'(quarterVal(j));
  end

  logic [AW-1:0]        laneAddr [2];
  logic signed [SW-1:0] laneOut  [2];
  assign laneAddr[0] = addr;
  assign laneAddr[1] = addr + AW'(Q);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [1:0]    quad;
    logic [AW-3:0] low;
    logic [AW-2:0] tIdx;
    logic [SW-1:0] mag;
    assign quad = laneAddr[l][AW-1 -: 2];
    assign low  = laneAddr[l][AW-3:0];
    assign tIdx = quad[0] ? ((AW-1)'(Q) - {1'b0, low}) : {1'b0, low};
    assign mag  = quarterTab[tIdx];
    always_ff @(posedge clk) begin
      if (rst) laneOut[l] <= '0;
      else     laneOut[l] <= quad[1] ? -mag : mag;
    end
  end

  assign sinOut = laneOut[0];
  assign cosOut = laneOut[1];

  AST_SIN_NOT_MIN: assert property (@(posedge clk) disable iff (rst)
    sinOut != {1'b1, {(SW-1){1'b0}}} && cosOut != {1'b1, {(SW-1){1'b0}}}); // R4
  AST_QUAD0_SIGN: assert property (@(posedge clk) disable iff (rst)
    addr[AW-1 -: 2] == 2'b00 |=> !sinOut[SW-1] && !cosOut[SW-1]); // R4
  AST_QUAD2_SIGN: assert property (@(posedge clk) disable iff (rst)
    addr[AW-1 -: 2] == 2'b10 |=> sinOut <= 0 && cosOut <= 0); // R4
endmodule

// File: rtl/toneChannel.sv
module toneChannel
  import dtgPkg::*;
#(
  parameter int FW  = 48,
  parameter int PHW = 16,
  parameter int AMW = 16,
  parameter int SW  = 16,
  parameter int AW  = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dtgStrobes_t           ctl,
  input  logic [FW-1:0]         freq,
  input  logic [PHW-1:0]        phase,
  input  logic signed [AMW-1:0] amp,
  output logic signed [AMW-1:0] iScaled,
  output logic signed [AMW-1:0] qScaled
);
  localparam int PW = AMW + SW;

  logic [FW-1:0]         accReg;
  logic [FW-1:0]         accBase;
  logic [PHW-1:0]        phaseIdx;
  logic signed [AMW-1:0] ampS1;
  logic signed [AMW-1:0] ampS2;
  logic signed [SW-1:0]  sinV;
  logic signed [SW-1:0]  cosV;
  logic signed [PW-1:0]  prodI;
  logic signed [PW-1:0]  prodQ;

  assign accBase = ctl.clear ? '0 : accReg;

  // stage 1: accumulate and offset
  always_ff @(posedge clk) begin
    if (rst) begin
      accReg   <= '0;
      phaseIdx <= '0;
      ampS1    <= '0;
    end else begin
      accReg   <= ctl.advance ? (accBase + freq) : accBase;
      phaseIdx <= accBase[FW-1 -: PHW] + phase;
      ampS1    <= amp;
    end
  end

  // stage 2: lookup (registered inside the table)
  sinCosLut #(.AW(AW), .SW(SW)) u_lut (
    .clk    (clk),
    .rst    (rst),
    .addr   (phaseIdx[PHW-1 -: AW]),
    .sinOut (sinV),
    .cosOut (cosV)
  );

  always_ff @(posedge clk) begin
    if (rst) ampS2 <= '0;
    else     ampS2 <= ampS1;
  end

  // stage 3: scale
  assign prodI = ampS2 * cosV;
  assign prodQ = ampS2 * sinV;

  always_ff @(posedge clk) begin
    if (rst) begin
      iScaled <= '0;
      qScaled <= '0;
    end else begin
      iScaled <= AMW'(prodI >>> (SW - 1));
      qScaled <= AMW'(prodQ >>> (SW - 1));
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.advance && !ctl.clear |=> $stable(accReg)); // R7
  AST_CLEAR_ADV: assert property (@(posedge clk) disable iff (rst)
    ctl.clear && ctl.advance |=> accReg == $past(freq)); // R8
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    ctl.clear && !ctl.advance |=> accReg == '0); // R8
  AST_PHASE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> phaseIdx == $past(phase)); // R3
  AST_ZERO_AMP: assert property (@(posedge clk) disable iff (rst)
    ampS2 == '0 |=> iScaled == '0 && qScaled == '0); // R5
endmodule

// File: rtl/bbCtrl.sv
module bbCtrl
  import dtgPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleEn,
  input  logic        phaseClear,
  output dtgStrobes_t ctl,
  output logic        outValid
);
  logic [PIPE_STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vPipe    <= '0;
      outValid <= 1'b0;
    end else begin
      vPipe    <= {vPipe[PIPE_STAGES-2:0], sampleEn};
      outValid <= vPipe[PIPE_STAGES-1];
    end
  end

  always_comb begin
    ctl.advance = sampleEn;
    ctl.clear   = phaseClear;
    ctl.loadOut = vPipe[PIPE_STAGES-1];
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(sampleEn, 4)); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    ctl.loadOut |=> outValid); // R2
endmodule

// File: rtl/bbDatapath.sv
module bbDatapath
  import dtgPkg::*;
#(
  parameter int NT  = NUM_TONES,
  parameter int FW  = 48,
  parameter int PHW = 16,
  parameter int AMW = 16,
  parameter int SW  = 16,
  parameter int AW  = 10,
  parameter int OW  = AMW + $clog2(NT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dtgStrobes_t          ctl,
  input  logic [FW-1:0]        freqIn  [NT],
  input  logic [PHW-1:0]       phaseIn [NT],
  input  logic [AMW-1:0]       ampIn   [NT],
  output logic signed [OW-1:0] sumIOut,
  output logic signed [OW-1:0] sumQOut
);
  logic signed [AMW-1:0] toneI [NT];
  logic signed [AMW-1:0] toneQ [NT];

  for (genvar t = 0; t < NT; t++) begin : g_tone
    toneChannel #(
      .FW(FW), .PHW(PHW), .AMW(AMW), .SW(SW), .AW(AW)
    ) u_tone (
      .clk     (clk),
      .rst     (rst),
      .ctl     (ctl),
      .freq    (freqIn[t]),
      .phase   (phaseIn[t]),
      .amp     (ampIn[t]),
      .iScaled (toneI[t]),
      .qScaled (toneQ[t])
    );
  end

  logic signed [OW-1:0] sumI;
  logic signed [OW-1:0] sumQ;
  logic                 allPosI;
  logic                 allNegI;

  always_comb begin
    sumI    = '0;
    sumQ    = '0;
    allPosI = 1'b1;
    allNegI = 1'b1;
    for (int t = 0; t < NT; t++) begin
      sumI    = sumI + OW'(toneI[t]);
      sumQ    = sumQ + OW'(toneQ[t]);
      allPosI = allPosI & ~toneI[t][AMW-1];
      allNegI = allNegI & toneI[t][AMW-1];
    end
  end

  // stage 4: output register, loaded only for accepted samples
  always_ff @(posedge clk) begin
    if (rst) begin
      sumIOut <= '0;
      sumQOut <= '0;
    end else if (ctl.loadOut) begin
      sumIOut <= sumI;
      sumQOut <= sumQ;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ctl.loadOut && allPosI |=> !sumIOut[OW-1]); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    ctl.loadOut && allNegI |=> sumIOut[OW-1]); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadOut |=> $stable(sumIOut) && $stable(sumQOut)); // R7
endmodule

// File: rtl/dualToneGen.sv
module dualToneGen
  import dtgPkg::*;
#(
  parameter int FREQ_W  = 48,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 16,
  parameter int SIN_W   = 16,
  parameter int LUT_AW  = 10,
  localparam int OUT_W  = AMP_W + $clog2(NUM_TONES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleEn,
  input  logic                phaseClear,
  input  logic [FREQ_W-1:0]   freqA,
  input  logic [PHASE_W-1:0]  phaseA,
  input  logic [AMP_W-1:0]    ampA,
  input  logic [FREQ_W-1:0]   freqB,
  input  logic [PHASE_W-1:0]  phaseB,
  input  logic [AMP_W-1:0]    ampB,
  output logic [OUT_W-1:0]    outI,
  output logic [OUT_W-1:0]    outQ,
  output logic                outValid
);
  dtgStrobes_t ctl;

  logic [FREQ_W-1:0]  freqArr  [NUM_TONES];
  logic [PHASE_W-1:0] phaseArr [NUM_TONES];
  logic [AMP_W-1:0]   ampArr   [NUM_TONES];
  logic signed [OUT_W-1:0] sumI;
  logic signed [OUT_W-1:0] sumQ;

  assign freqArr[0]  = freqA;
  assign freqArr[1]  = freqB;
  assign phaseArr[0] = phaseA;
  assign phaseArr[1] = phaseB;
  assign ampArr[0]   = ampA;
  assign ampArr[1]   = ampB;

  bbCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleEn   (sampleEn),
    .phaseClear (phaseClear),
    .ctl        (ctl),
    .outValid   (outValid)
  );

  bbDatapath #(
    .NT(NUM_TONES), .FW(FREQ_W), .PHW(PHASE_W), .AMW(AMP_W),
    .SW(SIN_W), .AW(LUT_AW), .OW(OUT_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .freqIn  (freqArr),
    .phaseIn (phaseArr),
    .ampIn   (ampArr),
    .sumIOut (sumI),
    .sumQOut (sumQ)
  );

  assign outI = sumI;
  assign outQ = sumQ;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !outValid && outI == '0 && outQ == '0); // R1
endmodule

// File: tb/sim_dualToneGen.sv
module sim_dualToneGen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst;
  logic               sampleEn;
  logic               phaseClear;
  logic [47:0]        freqA, freqB;
  logic [15:0]        phaseA, phaseB;
  logic [15:0]        ampA, ampB;
  logic signed [16:0] outI, outQ;
  logic               outValid;

  dualToneGen u0 (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .phaseClear(phaseClear),
    .freqA(freqA), .phaseA(phaseA), .ampA(ampA),
    .freqB(freqB), .phaseB(phaseB), .ampB(ampB),
    .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint expIQ[$];
  longint expQQ[$];
  int     expEdge[$];
  string  expTag[$];
  logic [47:0] mAcc [2];
  longint lastI = 0, lastQ = 0;

  function automatic longint tabv(int j);
    longint u, d;
    u = longint'(j) * longint'(512 - j);
    d = 327680 - u;
    return (longint'(32767) * 4 * u + d / 2) / d;
  endfunction

  function automatic longint sinv(int n);
    int q, m;
    longint mag;
    q = (n >> 8) & 3;
    m = n & 255;
    mag = tabv((q & 1) ? 256 - m : m);
    return (q & 2) ? -mag : mag;
  endfunction

  function automatic longint cosv(int n);
    return sinv((n + 256) & 1023);
  endfunction

  task automatic check(string tag, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic monitor();
    if (rst) begin
      check("R1 valid in reset", longint'(outValid), 0);
      check("R1 I in reset", longint'(outI), 0);
      return;
    end
    if (outValid) begin
      if (expIQ.size() == 0) begin
        check("R2 unexpected valid", 1, 0);
      end else begin
        longint ei, eq;
        int ee;
        string tg;
        ei = expIQ.pop_front(); eq = expQQ.pop_front();
        ee = expEdge.pop_front(); tg = expTag.pop_front();
        check("R2 latency", longint'(cyc - ee), 3);
        check({tg, " I"}, longint'(outI), ei);
        check({tg, " Q"}, longint'(outQ), eq);
      end
      lastI = longint'(outI);
      lastQ = longint'(outQ);
    end else begin
      check("R7 I hold", longint'(outI), lastI);
      check("R7 Q hold", longint'(outQ), lastQ);
    end
  endtask

  task automatic step(bit en, bit clr, logic [47:0] fa, logic [15:0] pa, logic [15:0] aa,
                      logic [47:0] fb, logic [15:0] pb, logic [15:0] ab, string tag);
    logic [47:0] f [2];
    logic [15:0] p [2];
    logic [15:0] a [2];
    longint ei, eq;
    @(negedge clk);
    monitor();
    sampleEn = en; phaseClear = clr;
    freqA = fa; phaseA = pa; ampA = aa;
    freqB = fb; phaseB = pb; ampB = ab;
    if (rst) return;
    f[0] = fa; f[1] = fb; p[0] = pa; p[1] = pb; a[0] = aa; a[1] = ab;
    ei = 0; eq = 0;
    for (int t = 0; t < 2; t++) begin
      logic [47:0] base;
      logic [15:0] idx;
      base = clr ? 48'd0 : mAcc[t];
      idx = base[47:32] + p[t];
      if (en) begin
        ei += (longint'($signed(a[t])) * cosv(int'(idx[15:6]))) >>> 15;
        eq += (longint'($signed(a[t])) * sinv(int'(idx[15:6]))) >>> 15;
      end
      mAcc[t] = en ? base + f[t] : base;
    end
    if (en) begin
      expIQ.push_back(ei); expQQ.push_back(eq);
      expEdge.push_back(cyc + 1); expTag.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R7 idle");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; sampleEn = 0; phaseClear = 0;
    freqA = 0; freqB = 0; phaseA = 0; phaseB = 0; ampA = 0; ampB = 0;
    mAcc[0] = 0; mAcc[1] = 0;
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk); rst = 0;
    idle(3);
    check("R1 valid after reset", longint'(outValid), 0);

    // full-scale positive, phase 0: headroom
    step(1, 1, 0, 0, 16'h7fff, 0, 0, 16'h7fff, "R6 max");
    idle(4);
    // full-scale negative
    step(1, 1, 0, 0, 16'h8000, 0, 0, 16'h8000, "R6 min");
    // quarter-cycle offset on both
    step(1, 1, 0, 16'h4000, 16'h7fff, 0, 16'h4000, 16'h7fff, "R3 quarter");
    // three-quarter offset, mixed amplitudes, negative quadrants
    step(1, 1, 0, 16'hc000, 16'h4000, 0, 16'h9000, 16'h8000, "R4 quadrants");
    // tone B silent
    step(1, 1, 48'h0123_4567_89ab, 16'h1234, 16'h5555, 48'hffff_0000_0000, 16'h4321, 0, "R5 zero amp");
    step(1, 0, 48'h0123_4567_89ab, 16'h1234, 16'h5555, 48'hffff_0000_0000, 16'h4321, 0, "R5 zero amp");
    // accumulators hold through idle, then continue
    idle(6);
    step(1, 0, 48'h0123_4567_89ab, 16'h1234, 16'h5555, 48'hffff_0000_0000, 16'h4321, 16'h2000, "R7 resume");
    // clear without a sample, then sample
    step(0, 1, 48'h1, 0, 0, 48'h1, 0, 0, "R8 clear idle");
    step(1, 0, 48'h0, 16'h0100, 16'h7000, 0, 16'h0100, 16'h7000, "R8 after clear");
    // wrapping step
    step(1, 1, 48'hffff_ffff_ffff, 0, 16'h6000, 48'h8000_0000_0000, 0, 16'h6000, "R3 wrap");
    for (int k = 0; k < 8; k++)
      step(1, 0, 48'hffff_ffff_ffff, 0, 16'h6000, 48'h8000_0000_0000, 0, 16'h6000, "R3 wrap");
    // constrained random
    for (int k = 0; k < 3000; k++) begin
      bit en, clr;
      logic [47:0] fa, fb;
      logic [15:0] aa, ab;
      en  = ($urandom % 4) != 0;
      clr = ($urandom % 50) == 0;
      fa  = {$urandom, $urandom} & 48'h00ff_ffff_ffff;
      fb  = {$urandom, $urandom};
      aa  = 16'($urandom);
      ab  = (($urandom % 8) == 0) ? 16'd0 : 16'($urandom);
      step(en, clr, fa, 16'($urandom), aa, fb, 16'($urandom), ab, "R4 R5 random");
    end
    idle(6);
    check("R2 pending at end", longint'(expIQ.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule